// File: doc/BRIEF.md
# 3½-Digit Seven-Segment Display Decoder

This block takes the result of a conversion and turns it into drive levels for a 3½-digit seven-segment display. A result is made of three BCD digits (units, tens, hundreds), a flag for the leading "1", an over-range flag and a sign bit. When the result-valid strobe pulses and hold is low, the result is captured in a display latch. The latch content is then decoded into 23 active-high segment lines:

- seven segments for each of the three full digits;
- one line that lights both segments of the leading "1";
- one line for the minus sign.

Two overrides act on the decoded view and never on the latch. Over-range blanks the three lower digits and forces the leading "1" on. Lamp test lights every segment. Hold freezes the latch, so the display keeps showing its last reading.

Top module: `seg35_display`

## Requirements
- R1: Each full digit decodes BCD codes 0 to 9 to the usual seven-segment shapes. The 7-bit segment vector is active high, with bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f, bit 6 = g. So 0 = 0x3F, 1 = 0x06, 2 = 0x5B, 3 = 0x4F, 4 = 0x66, 5 = 0x6D, 6 = 0x7D, 7 = 0x07, 8 = 0x7F and 9 = 0x6F.
- R2: A digit that holds a code from 10 to 15 shows all seven segments off.
- R3: Outside over-range and lamp test, the leading-one output equals the latched leading-one flag.
- R4: Outside lamp test, the minus output equals the latched sign bit, where 1 means negative. This holds for every reading, including an all-zero one.
- R5: On a rising clock edge where `res_valid` is 1 and `hold` is 0, the latch loads all inputs. The outputs show the new value right after that edge.
- R6: While `hold` is 1, a `res_valid` pulse leaves the latch and all outputs unchanged.
- R7: When the latched over-range flag is 1 and lamp test is off, the three full digits are all off, the leading-one output is 1, and the minus output keeps the latched sign.
- R8: While `lamp_test` is 1, all 23 outputs are 1 whatever the latched state. Lamp test does not alter the latch, and a load in that cycle still takes effect.
- R9: A synchronous active-high reset clears the latch, so the display shows 000 with the leading-one and minus outputs off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle strobe: a new result is present |
| hold | input | 1 | Freeze the display latch |
| lamp_test | input | 1 | Light every segment |
| neg_in | input | 1 | Sign of the result, 1 = negative |
| ovr_in | input | 1 | Over-range flag of the result |
| lead_in | input | 1 | Leading "1" flag of the result |
| bcd_units | input | 4 | Units BCD digit |
| bcd_tens | input | 4 | Tens BCD digit |
| bcd_hund | input | 4 | Hundreds BCD digit |
| seg_units | output | 7 | Units segments, bit 0 = a ... bit 6 = g |
| seg_tens | output | 7 | Tens segments |
| seg_hund | output | 7 | Hundreds segments |
| seg_lead | output | 1 | Both segments of the leading "1" |
| seg_minus | output | 1 | Minus sign |

## Verification
Lamp test can rise in the same cycle as a `res_valid` strobe. It can also coincide with a latched over-range state. The bench provokes both cases and expects all 23 lines high throughout. After lamp test is released, the bench expects the newly loaded value, or the blanked over-range view, with no trace of the override. Hold and `res_valid` can also coincide. A strobe under hold must leave every output showing the earlier reading, and the first strobe after hold drops must load normally.

// File: rtl/seg35_pkg.sv
package seg35_pkg;

    localparam int SEG_W   = 7;
    localparam int BCD_W   = 4;
    localparam int N_FULL  = 3;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [BCD_W-1:0] bcd_t;

    typedef struct packed {
        logic neg;
        logic ovr;
        logic lead;
        bcd_t hund;
        bcd_t tens;
        bcd_t units;
    } reading_t;

    localparam seg_t SEG_ALL = '1;
    localparam seg_t SEG_OFF = '0;

    // bit 0 = a ... bit 6 = g, active high
    function automatic seg_t bcd_to_seg(input bcd_t code);
        seg_t s;
        case (code)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = SEG_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seg35_latch.sv
module seg35_latch
    import seg35_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     hold,
    input  reading_t d,
    output reading_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load && !hold)
            q <= d;
    end

    a_r6_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(q));

    a_r5_load_takes: assert property (@(posedge clk) disable iff (rst)
        (load && !hold) |=> (q == $past(d)));

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/seg35_digit.sv
module seg35_digit
    import seg35_pkg::*;
(
    input  bcd_t code,
    input  logic blank,
    input  logic lamp,
    output seg_t seg
);

    always_comb begin
        if (lamp)
            seg = SEG_ALL;
        else if (blank)
            seg = SEG_OFF;
        else
            seg = bcd_to_seg(code);
    end

    always_comb begin
        if (lamp)
            a_r8_digit_lamp: assert (seg == SEG_ALL);
    end

endmodule

// File: rtl/seg35_display.sv
module seg35_display
    import seg35_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       res_valid,
    input  logic       hold,
    input  logic       lamp_test,
    input  logic       neg_in,
    input  logic       ovr_in,
    input  logic       lead_in,
    input  logic [3:0] bcd_units,
    input  logic [3:0] bcd_tens,
    input  logic [3:0] bcd_hund,
    output logic [6:0] seg_units,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_hund,
    output logic       seg_lead,
    output logic       seg_minus
);

    reading_t in_word;
    reading_t shown;
    bcd_t     codes [N_FULL];
    seg_t     segs  [N_FULL];

    assign in_word = '{neg: neg_in, ovr: ovr_in, lead: lead_in,
                       hund: bcd_hund, tens: bcd_tens, units: bcd_units};

    seg35_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .load (res_valid),
        .hold (hold),
        .d    (in_word),
        .q    (shown)
    );

    assign codes[0] = shown.units;
    assign codes[1] = shown.tens;
    assign codes[2] = shown.hund;

    for (genvar i = 0; i < N_FULL; i++) begin : g_digit
        seg35_digit u_dig (
            .code  (codes[i]),
            .blank (shown.ovr),
            .lamp  (lamp_test),
            .seg   (segs[i])
        );
    end

    assign seg_units = segs[0];
    assign seg_tens  = segs[1];
    assign seg_hund  = segs[2];
    assign seg_lead  = lamp_test | shown.ovr | shown.lead;
    assign seg_minus = lamp_test | shown.neg;

    a_r7_ovr_blanks: assert property (@(posedge clk) disable iff (rst)
        (!lamp_test && shown.ovr) |->
            (seg_units == '0 && seg_tens == '0 && seg_hund == '0 && seg_lead));

    a_r8_lamp_all_on: assert property (@(posedge clk) disable iff (rst)
        lamp_test |-> (&{seg_units, seg_tens, seg_hund, seg_lead, seg_minus}));

    a_r4_sign_after_load: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !hold && !lamp_test) |=> (lamp_test || seg_minus == $past(neg_in)));

endmodule

// File: tb/seg35_display_bench.sv
module seg35_display_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       res_valid = 1'b0, hold = 1'b0, lamp_test = 1'b0;
    logic       neg_in = 1'b0, ovr_in = 1'b0, lead_in = 1'b0;
    logic [3:0] bcd_units = '0, bcd_tens = '0, bcd_hund = '0;
    logic [6:0] seg_units, seg_tens, seg_hund;
    logic       seg_lead, seg_minus;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model latch
    int m_u = 0, m_t = 0, m_h = 0;
    bit m_neg = 0, m_ovr = 0, m_lead = 0;

    always #2 clk = ~clk;

    seg35_display u_seg35_display (
        .clk(clk), .rst(rst), .res_valid(res_valid), .hold(hold),
        .lamp_test(lamp_test), .neg_in(neg_in), .ovr_in(ovr_in),
        .lead_in(lead_in), .bcd_units(bcd_units), .bcd_tens(bcd_tens),
        .bcd_hund(bcd_hund), .seg_units(seg_units), .seg_tens(seg_tens),
        .seg_hund(seg_hund), .seg_lead(seg_lead), .seg_minus(seg_minus)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_u = 0; m_t = 0; m_h = 0; m_neg = 0; m_ovr = 0; m_lead = 0;
        end else if (res_valid && !hold) begin
            m_u = bcd_units; m_t = bcd_tens; m_h = bcd_hund;
            m_neg = neg_in; m_ovr = ovr_in; m_lead = lead_in;
        end
    end

    function automatic logic [6:0] shape(input int v);
        case (v)
            0: return 7'b0111111;
            1: return 7'b0000110;
            2: return 7'b1011011;
            3: return 7'b1001111;
            4: return 7'b1100110;
            5: return 7'b1101101;
            6: return 7'b1111101;
            7: return 7'b0000111;
            8: return 7'b1111111;
            9: return 7'b1101111;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [6:0] exp_dig(input int v);
        if (lamp_test) return 7'h7F;
        if (m_ovr) return 7'h00;
        return shape(v);
    endfunction

    function automatic string tag(input int v);
        if (lamp_test) return "R8";
        if (m_ovr) return "R7";
        return (v > 9) ? "R2" : "R1";
    endfunction

    task automatic compare_all();
        chk({tag(m_u), " units"}, seg_units, exp_dig(m_u));
        chk({tag(m_t), " tens"},  seg_tens,  exp_dig(m_t));
        chk({tag(m_h), " hund"},  seg_hund,  exp_dig(m_h));
        chk(lamp_test ? "R8 lead" : (m_ovr ? "R7 lead" : "R3 lead"),
            seg_lead, lamp_test | m_ovr | m_lead);
        chk(lamp_test ? "R8 minus" : "R4 minus", seg_minus, lamp_test | m_neg);
    endtask

    // one cycle: compare the current view, then drive new inputs
    task automatic step(input bit v, input bit h, input bit lt, input bit n,
                        input bit o, input bit l, input int u, input int t,
                        input int hu);
        @(negedge clk);
        if (!rst) compare_all();
        res_valid = v; hold = h; lamp_test = lt; neg_in = n; ovr_in = o;
        lead_in = l; bcd_units = 4'(u); bcd_tens = 4'(t); bcd_hund = 4'(hu);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, hold, lamp_test, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset units", seg_units, 7'h3F);
        chk("R9 reset lead", seg_lead, 0);
        chk("R9 reset minus", seg_minus, 0);

        // R1 R2: every code in every position
        for (int c = 0; c < 16; c++) begin
            step(1, 0, 0, c[0], 0, c[1], c, (c + 5) % 16, (c + 11) % 16);
            step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        end
        // R4: negative zero reading keeps the sign
        step(1, 0, 0, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R4 negative zero", seg_minus, 1);

        // R5: load visible right after the edge
        step(1, 0, 0, 0, 0, 1, 3, 2, 1);
        @(negedge clk);
        chk("R5 loaded units", seg_units, 7'h4F);
        chk("R5 loaded lead", seg_lead, 1);

        // R6: hold with a strobe leaves everything
        step(1, 1, 0, 1, 1, 0, 9, 9, 9);
        step(0, 1, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R6 hold units", seg_units, 7'h4F);
        chk("R6 hold minus", seg_minus, 0);
        step(1, 0, 0, 0, 0, 0, 7, 7, 7);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R7: over-range, negative and positive
        step(1, 0, 0, 1, 1, 0, 4, 5, 6);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R7 ovr blank", {seg_units, seg_tens, seg_hund}, 0);
        chk("R7 ovr lead", seg_lead, 1);
        chk("R7 ovr sign", seg_minus, 1);
        step(1, 0, 0, 0, 1, 1, 8, 8, 8);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R8: lamp test during over-range, then with a load in the same cycle
        step(0, 0, 1, 0, 0, 0, 0, 0, 0);
        idle(2);
        step(1, 0, 1, 0, 0, 0, 2, 4, 6);
        step(0, 0, 1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R8 after release units", seg_units, 7'h5B);
        chk("R8 after release hund", seg_hund, 7'h7D);
        // lamp test under hold
        step(1, 1, 1, 1, 1, 1, 1, 1, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R6 R8 hold+lamp tens", seg_tens, 7'h66);

        // R9 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R9 reset again hund", seg_hund, 7'h3F);
        chk("R9 reset again minus", seg_minus, 0);
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule